// File: doc/BRIEF.md
# Counter-Array Capture/Compare Channel

This block is one channel of a programmable counter array. A shared free-running 16-bit counter is supplied as an input, together with a strobe that marks the cycles on which the counter advances. The channel owns one external pin. Its input side can latch the counter value on a chosen edge of the pin. Its output side can flag a 16-bit compare match, invert the pin on every match, or drive an 8-bit pulse-width-modulated waveform.

Software programs the channel through a byte-wide write port. The port reaches a mode register and the low and high halves of the shared capture/compare register, and all three read back on dedicated outputs. Writing the low compare half turns the comparator off and writing the high half turns it back on. Loading low then high therefore cannot produce a match against a half-updated value. A sticky event flag records captures and enabled matches and stays set until a clear strobe arrives. The flag, gated by an enable bit, forms the interrupt request.

Top module: `ctr_capcmp_unit`

## Requirements
- R1: After synchronous reset, mode_q, cap_lo, cap_hi, flag, irq and pin_out are all zero.
- R2: A write with wr_sel=0 loads the mode register from wr_data. Bit 7 always reads back as 0. wr_sel=3 changes no register.
- R3: A write with wr_sel=1 loads cap_lo and clears mode bit 6 (comparator enable). A write with wr_sel=2 loads cap_hi and sets mode bit 6.
- R4: Capture happens on rising edges of pin_in when mode bit 5 is set and on falling edges when mode bit 4 is set, on either edge when both are set. The edge passes a two-flop synchronizer, and cnt_val is latched into {cap_hi,cap_lo} at the third rising clock edge after the pin changes.
- R5: Every capture sets flag. With mode bits 5:4 both clear, pin edges change neither the capture register nor flag.
- R6: When mode bits 6 and 3 are set and cnt_val equals {cap_hi,cap_lo} on a cycle with cnt_step high, flag is set at the next clock edge. No match is taken while cnt_step is low or bit 6 is clear.
- R7: When mode bits 6, 3 and 2 are set and PWM mode is off, pin_out inverts on every match event.
- R8: irq is high exactly when flag is set and mode bit 0 is set.
- R9: flag stays set until a flag_clr pulse clears it. A set event in the same cycle as flag_clr wins.
- R10: With mode bit 1 set, pin_out goes low one cycle after cnt_val[7:0] is below cap_lo and high otherwise. On a cnt_step cycle with cnt_val[7:0]=0xFF, cap_hi is copied into cap_lo.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared counter value, high byte over low byte |
| cnt_step | input | 1 | Counter-advance strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 low byte, 2 high byte, 3 none |
| wr_data | input | 8 | Write data |
| flag_clr | input | 1 | Clears the event flag |
| pin_in | input | 1 | External pin, asynchronous |
| mode_q | output | 8 | Mode register readback |
| cap_lo | output | 8 | Low capture/compare byte |
| cap_hi | output | 8 | High capture/compare byte |
| flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |
| pin_out | output | 1 | Output pin drive |

## Verification
The assertions assume at most one register write per cycle. They also assume that the mode-register readback reflects the current mode, so that a cycle with no write, PWM off and cnt_step low cannot move the output pin. They further assume that with both edge selects clear and PWM off, only software writes alter the capture register. The directed stimulus drives every input half a period away from the sampling edge. It issues writes one at a time, holds cnt_val steady across each synchronizer window, and raises cnt_step only on the cycles meant to produce a match or a PWM reload.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int MODE_W = 8;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Bit 0 at the bottom: irq_en ... bit 7 spare
    typedef struct packed {
        logic spare;
        logic cmp_en;
        logic cap_pos;
        logic cap_neg;
        logic mat_en;
        logic tog_en;
        logic pwm_en;
        logic irq_en;
    } mode_t;

    function automatic mode_t mode_from_byte(input logic [MODE_W-1:0] b);
        mode_t m;
        m       = mode_t'(b);
        m.spare = 1'b0;
        return m;
    endfunction

    function automatic logic toggle_active(input mode_t m);
        return m.tog_en & m.mat_en & m.cmp_en;
    endfunction

endpackage

// File: rtl/capcmp_edge_sync.sv
module capcmp_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic rise_en,
    input  logic fall_en,
    output logic edge_hit
);
    // stages [0..SYNC_STAGES-1] synchronize, the last one holds the prior sample
    logic [SYNC_STAGES:0] shreg;
    logic cur_s;
    logic prev_s;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SYNC_STAGES-1:0], pin};
    end

    assign cur_s    = shreg[SYNC_STAGES-1];
    assign prev_s   = shreg[SYNC_STAGES];
    assign edge_hit = (rise_en & cur_s & ~prev_s) | (fall_en & ~cur_s & prev_s);
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_step,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_en,
    output logic             match_ev,
    output logic             pwm_lvl,
    output logic             low_wrap
);
    localparam int BYTE_W = CNT_W / 2;

    assign match_ev = cnt_step & cmp_en & (cnt_val == cmp_val);
    assign pwm_lvl  = (cnt_val[BYTE_W-1:0] >= cmp_val[BYTE_W-1:0]);
    assign low_wrap = cnt_step & (&cnt_val[BYTE_W-1:0]);
endmodule

// File: rtl/ctr_capcmp_unit.sv
module ctr_capcmp_unit
    import capcmp_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CNT_W-1:0]      cnt_val,
    input  logic                  cnt_step,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [CNT_W/2-1:0]    wr_data,
    input  logic                  flag_clr,
    input  logic                  pin_in,
    output logic [MODE_W-1:0]     mode_q,
    output logic [CNT_W/2-1:0]    cap_lo,
    output logic [CNT_W/2-1:0]    cap_hi,
    output logic                  flag,
    output logic                  irq,
    output logic                  pin_out
);
    localparam int BYTE_W = CNT_W / 2;

    mode_t            mode_r;
    logic [CNT_W-1:0] cmp_r;
    logic             flag_r;
    logic             tog_r;
    logic             pwm_r;

    logic edge_hit, match_ev, pwm_lvl, low_wrap;
    logic wr_mode, wr_lo, wr_hi, set_ev;

    assign wr_mode = wr_en && (reg_sel_e'(wr_sel) == SEL_MODE);
    assign wr_lo   = wr_en && (reg_sel_e'(wr_sel) == SEL_LO);
    assign wr_hi   = wr_en && (reg_sel_e'(wr_sel) == SEL_HI);

    capcmp_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (pin_in),
        .rise_en  (mode_r.cap_pos),
        .fall_en  (mode_r.cap_neg),
        .edge_hit (edge_hit)
    );

    capcmp_match #(.CNT_W(CNT_W)) u_match (
        .cnt_val  (cnt_val),
        .cnt_step (cnt_step),
        .cmp_val  (cmp_r),
        .cmp_en   (mode_r.cmp_en),
        .match_ev (match_ev),
        .pwm_lvl  (pwm_lvl),
        .low_wrap (low_wrap)
    );

    // Mode register; compare-byte writes steer the comparator enable
    always_ff @(posedge clk) begin
        if (rst)          mode_r <= '0;
        else if (wr_mode) mode_r <= mode_from_byte(wr_data);
        else if (wr_lo)   mode_r.cmp_en <= 1'b0;
        else if (wr_hi)   mode_r.cmp_en <= 1'b1;
    end

    // Capture/compare register: software write, then capture, then PWM reload
    always_ff @(posedge clk) begin
        if (rst)                            cmp_r <= '0;
        else if (wr_lo)                     cmp_r[BYTE_W-1:0] <= wr_data;
        else if (wr_hi)                     cmp_r[CNT_W-1:BYTE_W] <= wr_data;
        else if (edge_hit)                  cmp_r <= cnt_val;
        else if (mode_r.pwm_en && low_wrap) cmp_r[BYTE_W-1:0] <= cmp_r[CNT_W-1:BYTE_W];
    end

    assign set_ev = edge_hit | (match_ev & mode_r.mat_en);

    always_ff @(posedge clk) begin
        if (rst)           flag_r <= 1'b0;
        else if (set_ev)   flag_r <= 1'b1;
        else if (flag_clr) flag_r <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                                    tog_r <= 1'b0;
        else if (match_ev && toggle_active(mode_r)) tog_r <= ~tog_r;
    end

    always_ff @(posedge clk) begin
        if (rst) pwm_r <= 1'b0;
        else     pwm_r <= pwm_lvl;
    end

    assign mode_q  = mode_r;
    assign cap_lo  = cmp_r[BYTE_W-1:0];
    assign cap_hi  = cmp_r[CNT_W-1:BYTE_W];
    assign flag    = flag_r;
    assign irq     = flag_r & mode_r.irq_en;
    assign pin_out = mode_r.pwm_en ? pwm_r : tog_r;
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              cnt_step,
    input logic              flag_clr,
    input logic              flag,
    input logic              irq,
    input logic [7:0]        mode_q,
    input logic [BYTE_W-1:0] cap_lo,
    input logic [BYTE_W-1:0] cap_hi,
    input logic              pin_out
);
    // R3
    lo_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd1) |=> !mode_q[6]);

    // R3
    hi_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd2) |=> mode_q[6]);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R7
    pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[1] && !cnt_step && !wr_en) |=> $stable(pin_out));

    // R5
    no_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && mode_q[5:4] == 2'b00 && !mode_q[1]) |=> $stable({cap_hi, cap_lo}));

    // R2
    spare_bit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !mode_q[7]);
endmodule

bind ctr_capcmp_unit capcmp_chk #(.BYTE_W(CNT_W/2)) u_capcmp_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .cnt_step (cnt_step),
    .flag_clr (flag_clr),
    .flag     (flag),
    .irq      (irq),
    .mode_q   (mode_q),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .pin_out  (pin_out)
);

// File: tb/test_ctr_capcmp_unit.sv
module test_ctr_capcmp_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_step = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic [7:0]  mode_q, cap_lo, cap_hi;
    logic        flag, irq, pin_out;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ctr_capcmp_unit i_ctr_capcmp_unit (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_step(cnt_step),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flag_clr(flag_clr),
        .pin_in(pin_in), .mode_q(mode_q), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .flag(flag), .irq(irq), .pin_out(pin_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode", mode_q, 8'h00);
        chk("R1 cap", {cap_hi, cap_lo}, 16'h0000);
        chk("R1 flag/irq/pin", {flag, irq, pin_out}, 3'b000);
    endtask

    task automatic t_mode_rw();
        wr(2'd0, 8'hFF);
        chk("R2 spare bit reads 0", mode_q, 8'h7F);
        wr(2'd0, 8'h00);
        chk("R2 mode write", mode_q, 8'h00);
        wr(2'd3, 8'hAB);
        chk("R2 sel3 no effect", {mode_q, cap_hi, cap_lo}, 24'h000000);
    endtask

    task automatic t_autoen();
        wr(2'd0, 8'h40);
        wr(2'd1, 8'h5A);
        chk("R3 low write clears enable", mode_q, 8'h00);
        chk("R3 low byte", cap_lo, 8'h5A);
        wr(2'd2, 8'hC3);
        chk("R3 high write sets enable", mode_q, 8'h40);
        chk("R3 high byte", cap_hi, 8'hC3);
    endtask

    task automatic t_capture();
        wr(2'd0, 8'h20);
        clear_flag();
        cnt_val = 16'hA5C3; pin_in = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 not yet captured", flag, 1'b0);
        @(negedge clk);
        chk("R4 rise capture", {cap_hi, cap_lo}, 16'hA5C3);
        chk("R5 capture sets flag", flag, 1'b1);
        cnt_val = 16'h1111; pin_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 fall ignored in rise mode", {cap_hi, cap_lo}, 16'hA5C3);
        wr(2'd0, 8'h10);
        pin_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R4 rise ignored in fall mode", {cap_hi, cap_lo}, 16'hA5C3);
        cnt_val = 16'h2222; pin_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 fall capture", {cap_hi, cap_lo}, 16'h2222);
        wr(2'd0, 8'h30);
        cnt_val = 16'h3333; pin_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 both: rise", {cap_hi, cap_lo}, 16'h3333);
        cnt_val = 16'h4444; pin_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 both: fall", {cap_hi, cap_lo}, 16'h4444);
        wr(2'd0, 8'h00);
        clear_flag();
        cnt_val = 16'h5555; pin_in = 1'b1;
        repeat (4) @(negedge clk);
        pin_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 no capture when disabled", {cap_hi, cap_lo}, 16'h4444);
        chk("R5 flag untouched", flag, 1'b0);
    endtask

    task automatic t_match();
        wr(2'd0, 8'h08);
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h12);
        chk("R3 enable after pair", mode_q, 8'h48);
        cnt_val = 16'h1234; cnt_step = 1'b0;
        @(negedge clk);
        chk("R6 no match without step", flag, 1'b0);
        cnt_val = 16'h1235; cnt_step = 1'b1;
        @(negedge clk);
        chk("R6 no match on unequal", flag, 1'b0);
        cnt_val = 16'h1234;
        @(negedge clk);
        cnt_step = 1'b0;
        chk("R6 match sets flag", flag, 1'b1);
        clear_flag();
        wr(2'd1, 8'h34);
        cnt_step = 1'b1;
        @(negedge clk);
        cnt_step = 1'b0;
        chk("R6 no match with enable cleared", flag, 1'b0);
    endtask

    task automatic t_toggle();
        wr(2'd0, 8'h0C);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h50);
        chk("R7 pin before match", pin_out, 1'b0);
        cnt_val = 16'h5000; cnt_step = 1'b1;
        @(negedge clk);
        chk("R7 first toggle", pin_out, 1'b1);
        cnt_val = 16'h5001;
        @(negedge clk);
        chk("R7 hold on unequal", pin_out, 1'b1);
        cnt_val = 16'h5000;
        @(negedge clk);
        cnt_step = 1'b0;
        chk("R7 second toggle", pin_out, 1'b0);
    endtask

    task automatic t_irq_flag();
        wr(2'd0, 8'h4D);
        chk("R8 irq with flag and enable", {flag, irq}, 2'b11);
        clear_flag();
        chk("R9 clear strobe", {flag, irq}, 2'b00);
        @(negedge clk);
        chk("R9 stays clear", flag, 1'b0);
        cnt_val = 16'h5000; cnt_step = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        cnt_step = 1'b0; flag_clr = 1'b0;
        chk("R9 set beats clear", flag, 1'b1);
        wr(2'd0, 8'h4C);
        chk("R8 irq masked", {flag, irq}, 2'b10);
    endtask

    task automatic t_pwm();
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h80);
        wr(2'd2, 8'h40);
        cnt_val = 16'h007F;
        @(negedge clk);
        chk("R10 below duty low", pin_out, 1'b0);
        cnt_val = 16'h0080;
        @(negedge clk);
        chk("R10 at duty high", pin_out, 1'b1);
        cnt_val = 16'h00FF; cnt_step = 1'b1;
        @(negedge clk);
        cnt_step = 1'b0;
        chk("R10 reload on wrap", {cap_hi, cap_lo}, 16'h4040);
        cnt_val = 16'h003F;
        @(negedge clk);
        chk("R10 new duty low", pin_out, 1'b0);
        cnt_val = 16'h0040;
        @(negedge clk);
        chk("R10 new duty high", pin_out, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_mode_rw();
        t_autoen();
        t_capture();
        t_match();
        t_toggle();
        t_irq_flag();
        t_pwm();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule